// File: doc/BRIEF.md
# Quadword to longword register packer

This block moves a 32-bit signed integer between its ordinary 64-bit two's-complement form and the scattered layout used when a longword is held in a 64-bit floating-point register. In that layout the top two bits of the longword sit at the top of the register, and the remaining thirty bits sit in a middle field. Every other register bit is zero.

Each strobe carries one operand and a direction. The pack direction builds the scattered layout from a quadword and checks that the quadword fits in 32 signed bits. When it does not fit, a sticky overflow flag is set, and a one-cycle trap request is raised if the instruction enabled overflow traps. The pack result is written even when the value overflows. The unpack direction gathers the two fields back into a longword and sign-extends it to 64 bits. Results appear one clock after the strobe.

Top module: `qlp_top`

## Requirements
- R1: Pack (dir_i = 0) places operand bits 31:30 at result bits 63:62 and operand bits 29:0 at result bits 58:29. Result bits 61:59 and 28:0 are zero.
- R2: Unpack (dir_i = 1) forms a 32-bit value whose bits 31:30 come from operand bits 63:62 and whose bits 29:0 come from operand bits 58:29. The value is sign-extended to 64 bits.
- R3: A pack overflows when the operand, read as signed, is above 0x000000007FFFFFFF or below 0xFFFFFFFF80000000.
- R4: A pack overflow sets ovf_sticky_o. The flag stays set until clr_i is asserted or reset is applied. An overflow in the same cycle as clr_i leaves the flag set.
- R5: trap_o pulses for exactly one cycle, together with valid_o, for a pack that overflows while trap_en_i is 1. It never pulses otherwise.
- R6: An overflowing pack still returns the R1 result on result_o.
- R7: Unpack never sets ovf_sticky_o or raises trap_o, whatever the operand and trap_en_i.
- R8: valid_o is high exactly one cycle after each valid_i. result_o holds its last value while no strobe arrives.
- R9: After reset, valid_o, trap_o, ovf_sticky_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| dir_i | input | 1 | 0 = pack, 1 = unpack |
| trap_en_i | input | 1 | Overflow trap enable for this operation |
| clr_i | input | 1 | Clears the sticky overflow flag |
| op_i | input | 64 | Operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Converted value |
| ovf_sticky_o | output | 1 | Sticky integer-overflow flag |
| trap_o | output | 1 | One-cycle overflow trap request |

## Verification
The bench sweeps values on both sides of the two range limits (0x7FFFFFFF against 0x80000000, and 0xFFFFFFFF80000000 against the value one below it), plus every single-bit and negated single-bit operand. A design with an off-by-one range test would flag or miss exactly one of these neighbours. Unpack operands are spread so that bits 63:62 and 58:29 take many patterns, including bit 63 set. A design that drops the sign extension, or reads the wrong field, would show wrong upper bits. The bench also drives a clear in the same cycle as an overflow, checks for a trap with the enable off, and checks that a trap does not outlast one cycle. A flag that clears itself, a clear that wins over a new overflow, or a trap that ignores the enable would each be caught.

// File: rtl/qlp_pkg.sv
package qlp_pkg;
  localparam int unsigned QW     = 64;  // register / quadword width
  localparam int unsigned LW     = 32;  // longword width
  localparam int unsigned HI_W   = 2;   // upper longword slice width
  localparam int unsigned LO_W   = LW - HI_W;
  localparam int unsigned HI_POS = QW - HI_W;  // register position of upper slice
  localparam int unsigned LO_POS = 29;         // register position of lower slice

  typedef enum logic {
    DIR_PACK   = 1'b0,
    DIR_UNPACK = 1'b1
  } qlp_dir_e;
endpackage

// File: rtl/qlp_pack.sv
module qlp_pack
  import qlp_pkg::*;
(
  input  logic [QW-1:0] src_i,
  output logic [QW-1:0] res_o,
  output logic          ovf_o
);
  logic [QW-LW:0] upper;  // bits that must all equal the longword sign

  always_comb begin
    res_o = '0;
    res_o[HI_POS +: HI_W] = src_i[LO_W +: HI_W];
    res_o[LO_POS +: LO_W] = src_i[0 +: LO_W];
  end

  assign upper = src_i[QW-1:LW-1];
  assign ovf_o = ~((&upper) | ~(|upper));
endmodule

// File: rtl/qlp_unpack.sv
module qlp_unpack
  import qlp_pkg::*;
(
  input  logic [QW-1:0] src_i,
  output logic [QW-1:0] res_o
);
  logic [LW-1:0] lw;

  assign lw    = {src_i[HI_POS +: HI_W], src_i[LO_POS +: LO_W]};
  assign res_o = {{(QW-LW){lw[LW-1]}}, lw};
endmodule

// File: rtl/qlp_top.sv
module qlp_top
  import qlp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          dir_i,
  input  logic          trap_en_i,
  input  logic          clr_i,
  input  logic [QW-1:0] op_i,
  output logic          valid_o,
  output logic [QW-1:0] result_o,
  output logic          ovf_sticky_o,
  output logic          trap_o
);
  qlp_dir_e      dir, dir_q;
  logic [QW-1:0] pack_res, unpack_res, res_d;
  logic          pack_ovf, ovf_hit;

  assign dir = qlp_dir_e'(dir_i);

  qlp_pack   u_pack   (.src_i(op_i), .res_o(pack_res),   .ovf_o(pack_ovf));
  qlp_unpack u_unpack (.src_i(op_i), .res_o(unpack_res));

  assign res_d   = (dir == DIR_PACK) ? pack_res : unpack_res;
  assign ovf_hit = valid_i && (dir == DIR_PACK) && pack_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      result_o     <= '0;
      ovf_sticky_o <= 1'b0;
      trap_o       <= 1'b0;
      dir_q        <= DIR_PACK;
    end else begin
      valid_o <= valid_i;
      trap_o  <= ovf_hit && trap_en_i;
      if (valid_i) begin
        result_o <= res_d;  // written even on overflow
        dir_q    <= dir;
      end
      // set wins over a simultaneous clear
      if (ovf_hit)    ovf_sticky_o <= 1'b1;
      else if (clr_i) ovf_sticky_o <= 1'b0;
    end
  end

  p_pack_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dir_q == DIR_PACK) |-> (result_o[61:59] == '0 && result_o[28:0] == '0));

  p_unpack_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dir_q == DIR_UNPACK) |->
      ($countones(result_o[63:31]) == 0 || $countones(result_o[63:31]) == 33));

  p_sticky_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_sticky_o && !clr_i) |=> ovf_sticky_o);

  p_trap_needs_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (valid_o && ovf_sticky_o));

  p_trap_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !trap_en_i) |=> !trap_o);

  p_unpack_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dir_i && !ovf_sticky_o && !clr_i) |=> (!trap_o && !ovf_sticky_o));

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && !valid_o));
endmodule

// File: tb/sim_qlp_top.sv
module sim_qlp_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, dir_i = 1'b0, trap_en_i = 1'b0, clr_i = 1'b0;
  logic [63:0] op_i = '0;
  logic        valid_o, ovf_sticky_o, trap_o;
  logic [63:0] result_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic sticky_exp = 1'b0;

  always #5 clk_i = ~clk_i;

  qlp_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_exp(input logic [63:0] v);
    return {v[31:30], 3'b000, v[29:0], 29'd0};
  endfunction

  function automatic logic [63:0] unpack_exp(input logic [63:0] r);
    logic [31:0] lw;
    lw = {r[63:62], r[58:29]};
    return 64'($signed(lw));
  endfunction

  function automatic bit ovf_exp(input logic [63:0] v);
    return ($signed(v) > 64'sd2147483647) || ($signed(v) < -64'sd2147483648);
  endfunction

  task automatic do_pack(input logic [63:0] v, input logic ten, input logic clr);
    bit o;
    o = ovf_exp(v);
    @(negedge clk_i);
    valid_i = 1; dir_i = 0; trap_en_i = ten; op_i = v; clr_i = clr;
    @(negedge clk_i);
    valid_i = 0; clr_i = 0;
    if (o) sticky_exp = 1'b1;
    else if (clr) sticky_exp = 1'b0;
    chk(result_o == pack_exp(v), o ? "R6 pack result on overflow" : "R1 pack layout", result_o, pack_exp(v));
    chk(valid_o == 1'b1, "R8 valid latency", 64'(valid_o), 64'd1);
    chk(ovf_sticky_o == sticky_exp, "R3 R4 sticky overflow", 64'(ovf_sticky_o), 64'(sticky_exp));
    chk(trap_o == (o && ten), "R5 trap request", 64'(trap_o), 64'(o && ten));
  endtask

  task automatic do_unpack(input logic [63:0] r, input logic ten);
    @(negedge clk_i);
    valid_i = 1; dir_i = 1; trap_en_i = ten; op_i = r;
    @(negedge clk_i);
    valid_i = 0;
    chk(result_o == unpack_exp(r), "R2 unpack sign extend", result_o, unpack_exp(r));
    chk(trap_o == 1'b0, "R7 unpack no trap", 64'(trap_o), 64'd0);
    chk(ovf_sticky_o == sticky_exp, "R7 unpack sticky unchanged", 64'(ovf_sticky_o), 64'(sticky_exp));
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    sticky_exp = 1'b0;
    chk(ovf_sticky_o == 1'b0, "R4 clear", 64'(ovf_sticky_o), 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 0 && trap_o == 0 && ovf_sticky_o == 0 && result_o == '0,
        "R9 reset state", result_o, 64'd0);
    rst_ni = 1;

    // range boundaries
    for (int d = -3; d <= 3; d++) begin
      do_pack(64'h7FFF_FFFF + 64'(d), d[0], 1'b0);
      do_clear();
      do_pack(64'hFFFF_FFFF_8000_0000 + 64'(d), ~d[0], 1'b0);
      do_clear();
    end
    // single bits and their negations
    for (int k = 0; k < 64; k++) begin
      do_pack(64'd1 << k, 1'b1, 1'b0);
      do_pack(-(64'd1 << k), 1'b0, 1'b0);
      do_clear();
    end
    // sticky persists across clean ops; set wins over clear
    do_pack(64'h1_0000_0000, 1'b0, 1'b0);
    do_pack(64'd5, 1'b0, 1'b0);
    do_unpack(64'h0, 1'b1);
    do_pack(64'h8000_0000, 1'b1, 1'b1);
    chk(ovf_sticky_o == 1'b1, "R4 set wins over clear", 64'(ovf_sticky_o), 64'd1);
    @(negedge clk_i);
    chk(trap_o == 1'b0, "R5 trap one cycle", 64'(trap_o), 64'd0);
    chk(valid_o == 1'b0, "R8 valid one cycle", 64'(valid_o), 64'd0);
    do_clear();

    // unpack spread
    for (int i = 0; i < 128; i++) begin
      do_unpack(64'(i) * 64'h9E37_79B9_7F4A_7C15 ^ (64'(i) << 58), i[0]);
    end
    do_unpack(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    do_unpack(64'h8000_0000_0000_0000, 1'b1);

    // hold while idle
    held = result_o;
    op_i = 64'hDEAD_BEEF_0000_1234;
    repeat (3) @(negedge clk_i);
    chk(result_o == held, "R8 result holds", result_o, held);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule